// File: doc/BRIEF.md
# Threshold-Flagged Byte FIFO Pair for a Serial Port

This block sits between a 32-bit register port and a byte-serial shifter. It holds two byte-wide queues: one for transmit and one for receive. On the transmit side, the register port writes whole words, which are split into bytes with the least significant byte first. The shifter then takes those bytes one at a time. On the receive side, the shifter deposits bytes one at a time, and the register port collects them as a word, again least significant byte first. A mode input selects whether a register access carries four bytes or a single byte.

Each queue drives a set of flags:
- a ready flag, set by comparing the queue against a programmable 3-bit threshold;
- full and empty flags;
- sticky overflow and underflow flags.

A flush command empties both queues and clears its own busy bit once the flush is done. A synchronous soft reset returns everything to idle. An enable input gates all traffic into and out of the queues.

Top module: `spf_fifo_pair`

## Requirements
- R1: After reset:
  - both empty flags read 1;
  - both full flags, all four sticky flags and `flush_busy` read 0.
- R2: In word mode (`word_mode`=1), a `wr_valid` pulse with `wr_last`=0 queues the four bytes of `wr_data`. The shifter sees them on `tx_byte` in the order bits [7:0], [15:8], [23:16], [31:24].
- R3: Partial words:
  - In word mode, `wr_last`=k (k in 1..3) queues only the k lowest bytes.
  - A word-mode `rd_req` with fewer than four bytes queued removes the bytes that are present. `rd_data` shows 0xFF in every lane that holds no byte.
- R4: In byte mode (`word_mode`=0), each access moves a single byte:
  - a write queues only `wr_data[7:0]`;
  - a read removes one byte and presents it in `rd_data[7:0]`, with 0xFF in bits [31:8].
- R5: In word mode, `rd_data` shows the four oldest receive bytes, oldest in [7:0]. `rd_req` removes all four.
- R6: Ready flags:
  - `rx_ready` is 1 exactly when the receive occupancy is greater than `rd_thresh`;
  - `tx_ready` is 1 exactly when the transmit free space is greater than `wr_thresh`.
- R7: Full and empty flags:
  - a full flag is 1 exactly when its queue holds DEPTH (8) bytes;
  - an empty flag is 1 exactly when its queue holds none.
- R8: A write that needs more room than is free is dropped whole and sets that queue's overflow flag (`tx_ovf` or `rx_ovf`). The queued bytes are left unchanged. The flag stays set until a flush or a reset.
- R9: A pop or read on an empty queue removes nothing and sets that queue's underflow flag (`tx_udf` or `rx_udf`). The flag stays set until a flush or a reset.
- R10: A `flush_req` pulse sets `flush_busy` on the next clock. On the following clock:
  - both queues empty;
  - all sticky flags clear;
  - `flush_busy` returns to 0.
- R11: A cycle with `soft_rst`=1 empties both queues and clears the sticky flags and `flush_busy`.
- R12: While `fifo_en`=0, `wr_valid`, `rd_req`, `tx_pop` and `rx_push` have no effect, and no sticky flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to idle |
| fifo_en | input | 1 | Enables queue traffic |
| word_mode | input | 1 | 1: four-byte accesses, 0: one-byte accesses |
| rd_thresh | input | 3 | Receive ready threshold |
| wr_thresh | input | 3 | Transmit ready threshold |
| flush_req | input | 1 | Pulse that starts a flush |
| flush_busy | output | 1 | Flush bit, cleared by hardware |
| wr_valid | input | 1 | Register-side write strobe |
| wr_data | input | 32 | Word to transmit |
| wr_last | input | 2 | Valid byte count of a partial word, 0 means full |
| rd_req | input | 1 | Register-side read strobe |
| rd_data | output | 32 | Received word view |
| tx_pop | input | 1 | Shifter takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter delivers one byte |
| rx_byte | input | 8 | Delivered byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ready | output | 1 | Transmit free space above threshold |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_ready | output | 1 | Receive occupancy above threshold |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The bench builds the block with its defaults: eight-byte queues, four-byte words and 3-bit thresholds. These values let two word writes fill the transmit queue, so a third write reaches the overflow case. A threshold of 3 sits in the middle of its range, so the ready flags can be observed on both sides of the comparison. Partial words and byte-mode accesses are reachable with the same build, because the lane count and queue depth leave room for leftover bytes.

// File: rtl/spf_pkg.sv
package spf_pkg;
   typedef logic [7:0] byte_t;
   localparam byte_t PAD_BYTE = 8'hFF;
endpackage

// File: rtl/spf_byte_fifo.sv
module spf_byte_fifo
   import spf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  push_req,
   input  logic [NW-1:0]         push_n,
   input  logic [LANES-1:0][7:0] push_lanes,
   input  logic                  pop_req,
   input  logic [NW-1:0]         pop_n,
   output logic [LANES-1:0][7:0] peek,
   output logic [CW-1:0]         count,
   output logic                  ovf,
   output logic                  udf
);
   byte_t           mem [DEPTH];
   logic [AW-1:0]   wr_ptr, rd_ptr;
   logic [CW-1:0]   free_sp;
   logic            push_ok, pop_ok;

   assign free_sp = CW'(DEPTH) - count;
   assign push_ok = push_req && (push_n != '0) && (CW'(push_n) <= free_sp);
   assign pop_ok  = pop_req && (pop_n != '0) && (CW'(pop_n) <= count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         udf    <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= PAD_BYTE;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         udf    <= 1'b0;
      end else begin
         if (push_ok) begin
            for (int i = 0; i < LANES; i++)
               if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_lanes[i];
            wr_ptr <= wr_ptr + AW'(push_n);
         end
         if (pop_ok) rd_ptr <= rd_ptr + AW'(pop_n);
         count <= count + (push_ok ? CW'(push_n) : '0) - (pop_ok ? CW'(pop_n) : '0);
         if (push_req && !push_ok) ovf <= 1'b1;
         if (pop_req && !pop_ok)   udf <= 1'b1;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_peek
      assign peek[g] = (CW'(g) < count) ? mem[rd_ptr + AW'(g)] : PAD_BYTE;
   end
endmodule

// File: rtl/spf_flush_ctl.sv
module spf_flush_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic flush_req,
   output logic flush_busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flush_busy <= 1'b0;
      else if (soft_rst)   flush_busy <= 1'b0;
      else if (flush_busy) flush_busy <= 1'b0;
      else                 flush_busy <= flush_req;
   end
endmodule

// File: rtl/spf_fifo_pair.sv
module spf_fifo_pair
   import spf_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int WORD_BYTES = 4,
   parameter int TH_W       = 3,
   localparam int DW = 8 * WORD_BYTES,
   localparam int LW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(WORD_BYTES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            fifo_en,
   input  logic            word_mode,
   input  logic [TH_W-1:0] rd_thresh,
   input  logic [TH_W-1:0] wr_thresh,
   input  logic            flush_req,
   output logic            flush_busy,
   input  logic            wr_valid,
   input  logic [DW-1:0]   wr_data,
   input  logic [LW-1:0]   wr_last,
   input  logic            rd_req,
   output logic [DW-1:0]   rd_data,
   input  logic            tx_pop,
   output logic [7:0]      tx_byte,
   input  logic            rx_push,
   input  logic [7:0]      rx_byte,
   output logic            tx_full,
   output logic            tx_empty,
   output logic            tx_ready,
   output logic            tx_ovf,
   output logic            tx_udf,
   output logic            rx_full,
   output logic            rx_empty,
   output logic            rx_ready,
   output logic            rx_ovf,
   output logic            rx_udf
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("spf_fifo_pair: DEPTH must be a power of two");
   end
   if (WORD_BYTES > DEPTH || WORD_BYTES < 1) begin : g_bad_word
      $error("spf_fifo_pair: WORD_BYTES must lie in 1..DEPTH");
   end
   if ((1 << TH_W) < DEPTH) begin : g_bad_thresh
      $error("spf_fifo_pair: TH_W too narrow for DEPTH");
   end

   logic                       clr;
   logic [WORD_BYTES-1:0][7:0] tx_lanes, tx_peek, rx_lanes, rx_peek;
   logic [CW-1:0]              tx_count, rx_count;
   logic [NW-1:0]              tx_push_n, rx_pop_n;

   spf_flush_ctl u_flush (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .flush_req(flush_req), .flush_busy(flush_busy)
   );

   assign clr      = soft_rst | flush_busy;
   assign tx_lanes = wr_data;

   always_comb begin
      if (!word_mode)         tx_push_n = NW'(1);
      else if (wr_last == '0) tx_push_n = NW'(WORD_BYTES);
      else                    tx_push_n = NW'(wr_last);
   end

   always_comb begin
      if (!word_mode)                      rx_pop_n = NW'(1);
      else if (rx_count >= CW'(WORD_BYTES)) rx_pop_n = NW'(WORD_BYTES);
      else                                 rx_pop_n = NW'(rx_count);
   end

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_rx_lane
      if (g == 0) begin : g_low
         assign rx_lanes[g] = rx_byte;
         assign rd_data[7:0] = rx_peek[0];
      end else begin : g_high
         assign rx_lanes[g] = PAD_BYTE;
         assign rd_data[8*g +: 8] = word_mode ? rx_peek[g] : PAD_BYTE;
      end
   end

   spf_byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push_req(wr_valid & fifo_en), .push_n(tx_push_n), .push_lanes(tx_lanes),
      .pop_req(tx_pop & fifo_en), .pop_n(NW'(1)),
      .peek(tx_peek), .count(tx_count), .ovf(tx_ovf), .udf(tx_udf)
   );

   spf_byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push_req(rx_push & fifo_en), .push_n(NW'(1)), .push_lanes(rx_lanes),
      .pop_req(rd_req & fifo_en), .pop_n(rx_pop_n),
      .peek(rx_peek), .count(rx_count), .ovf(rx_ovf), .udf(rx_udf)
   );

   assign tx_byte  = tx_peek[0];
   assign tx_full  = (tx_count == CW'(DEPTH));
   assign tx_empty = (tx_count == '0);
   assign rx_full  = (rx_count == CW'(DEPTH));
   assign rx_empty = (rx_count == '0);
   assign tx_ready = (32'(CW'(DEPTH) - tx_count) > 32'(wr_thresh));
   assign rx_ready = (32'(rx_count) > 32'(rd_thresh));
endmodule

// File: rtl/spf_fifo_pair_chk.sv
module spf_fifo_pair_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_rst,
   input logic flush_busy,
   input logic tx_full,
   input logic tx_empty,
   input logic tx_ovf,
   input logic tx_udf,
   input logic rx_full,
   input logic rx_empty,
   input logic rx_ready,
   input logic rx_ovf
);
   AST_TX_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty)); // R7
   AST_RX_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full && rx_empty)); // R7
   AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !rx_ready); // R6
   AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !flush_busy && !soft_rst) |=> tx_ovf); // R8
   AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf && !flush_busy && !soft_rst) |=> rx_ovf); // R8
   AST_TX_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_udf && !flush_busy && !soft_rst) |=> tx_udf); // R9
   AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> !flush_busy); // R10
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> (tx_empty && rx_empty && !tx_ovf && !rx_ovf)); // R10
   AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx_empty && rx_empty && !flush_busy)); // R11
endmodule

bind spf_fifo_pair spf_fifo_pair_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush_busy(flush_busy),
   .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
   .rx_full(rx_full), .rx_empty(rx_empty), .rx_ready(rx_ready), .rx_ovf(rx_ovf)
);

// File: tb/spf_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spf_fifo_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, fifo_en = 1'b1, word_mode = 1'b1;
   logic [2:0]  rd_thresh = 3'd3, wr_thresh = 3'd3;
   logic        flush_req = 1'b0, flush_busy;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic [1:0]  wr_last = '0;
   logic        rd_req = 1'b0;
   logic [31:0] rd_data;
   logic        tx_pop = 1'b0, rx_push = 1'b0;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic tx_full, tx_empty, tx_ready, tx_ovf, tx_udf;
   logic rx_full, rx_empty, rx_ready, rx_ovf, rx_udf;

   int n_tests = 0, n_fail = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   always #2 clk = ~clk;

   spf_fifo_pair dut_i (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   // driver: register write, expected bytes go to the scoreboard queue
   task automatic wr_word(logic [31:0] d, logic [1:0] last, bit expect_ok);
      int n = !word_mode ? 1 : (last == 0 ? 4 : int'(last));
      wr_valid = 1'b1; wr_data = d; wr_last = last;
      cyc();
      wr_valid = 1'b0;
      if (expect_ok) for (int i = 0; i < n; i++) txq.push_back(d[8*i +: 8]);
   endtask

   // monitor side of transmit: compare oldest byte, then take it
   task automatic tx_take(string req);
      chk(req, {24'h0, tx_byte}, {24'h0, txq.pop_front()});
      tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
   endtask

   task automatic rx_put(logic [7:0] b, bit expect_ok);
      rx_push = 1'b1; rx_byte = b; cyc(); rx_push = 1'b0;
      if (expect_ok) rxq.push_back(b);
   endtask

   task automatic rd_word(string req);
      logic [31:0] exp = 32'hFFFF_FFFF;
      int n = word_mode ? 4 : 1;
      for (int i = 0; i < n; i++)
         if (rxq.size() != 0) exp[8*i +: 8] = rxq.pop_front();
      chk(req, rd_data, exp);
      rd_req = 1'b1; cyc(); rd_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1; @(negedge clk);
      // R1 reset state
      chk("R1", {tx_empty, rx_empty, tx_full, rx_full, tx_ovf, tx_udf, rx_ovf, rx_udf, flush_busy},
          9'b110000000);

      // R2/R6/R7 word writes
      wr_word(32'h4433_2211, 2'd0, 1);
      chk("R6 tx_ready free4>3", tx_ready, 1);
      wr_word(32'h8877_6655, 2'd0, 1);
      chk("R6 tx_ready free0", tx_ready, 0);
      chk("R7 tx_full", tx_full, 1);
      // R8 overflow dropped
      wr_word(32'hDEAD_BEEF, 2'd0, 0);
      chk("R8 tx_ovf", tx_ovf, 1);
      for (int i = 0; i < 8; i++) tx_take("R2 byte order / R8 contents kept");
      chk("R7 tx_empty", tx_empty, 1);
      chk("R8 tx_ovf sticky", tx_ovf, 1);
      // R9 underflow
      tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
      chk("R9 tx_udf", tx_udf, 1);
      chk("R9 tx_empty", tx_empty, 1);

      // R3 partial transmit word
      wr_word(32'hCCBB_AA99, 2'd2, 1);
      tx_take("R3 partial tx");
      tx_take("R3 partial tx");
      chk("R3 only k bytes", tx_empty, 1);

      // R5/R6 receive word
      rx_put(8'hA1, 1); rx_put(8'hB2, 1); rx_put(8'hC3, 1);
      chk("R6 rx_ready occ3", rx_ready, 0);
      rx_put(8'hD4, 1);
      chk("R6 rx_ready occ4", rx_ready, 1);
      rd_word("R5 rx word");
      chk("R5 rx drained", rx_empty, 1);
      // R3 partial receive word
      rx_put(8'h5A, 1); rx_put(8'h6B, 1);
      rd_word("R3 partial rx pad");
      chk("R3 partial rx drained", rx_empty, 1);
      // R9 receive underflow
      rd_req = 1'b1; cyc(); rd_req = 1'b0;
      chk("R9 rx_udf", rx_udf, 1);
      // R8 receive overflow
      for (int i = 0; i < 8; i++) rx_put(8'(8'h10 + i), 1);
      chk("R7 rx_full", rx_full, 1);
      rx_put(8'hEE, 0);
      chk("R8 rx_ovf", rx_ovf, 1);
      rd_word("R8 rx kept");
      rd_word("R8 rx kept");

      // R4 byte mode
      word_mode = 1'b0;
      wr_word(32'hAABB_CCDD, 2'd0, 1);
      tx_take("R4 byte tx");
      chk("R4 one byte only", tx_empty, 1);
      rx_put(8'h3C, 1);
      rd_word("R4 byte rx");
      word_mode = 1'b1;

      // R10 flush
      wr_word(32'h0102_0304, 2'd0, 1);
      rx_put(8'h77, 1);
      flush_req = 1'b1; cyc(); flush_req = 1'b0;
      chk("R10 busy set", flush_busy, 1);
      cyc();
      chk("R10 flush done", {flush_busy, tx_empty, rx_empty, tx_ovf, tx_udf, rx_ovf, rx_udf},
          7'b0110000);
      txq.delete(); rxq.delete();

      // R11 soft reset
      wr_word(32'h1111_1111, 2'd0, 1);
      tx_pop = 1'b1; rd_req = 1'b1; cyc(); tx_pop = 1'b0; rd_req = 1'b0;
      soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
      chk("R11 soft reset", {tx_empty, rx_empty, rx_udf, flush_busy}, 4'b1100);
      txq.delete();

      // R12 disabled traffic ignored
      fifo_en = 1'b0;
      wr_word(32'h2222_2222, 2'd0, 0);
      rx_put(8'h99, 0);
      tx_pop = 1'b1; rd_req = 1'b1; cyc(); tx_pop = 1'b0; rd_req = 1'b0;
      chk("R12 ignored", {tx_empty, rx_empty, tx_ovf, tx_udf, rx_ovf, rx_udf}, 6'b110000);
      fifo_en = 1'b1;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule